// File: doc/BRIEF.md
# Masked Privileged Control Register File

This block holds the privileged 64-bit control registers of a processor core behind one indexed write port and one indexed read port. Each index carries its own access class and write mask. On a write, a register may store the full word, store only the bits its mask allows, or clear itself to zero. A register may also reject the write with a fault. A read returns the stored word, or it faults when the index is write-only or not present. Two write-only indices are translation-buffer maintenance commands. They store nothing and only produce a one-cycle strobe for the translation logic outside this block.

A cycle register keeps a stored upper half. On a read, that upper half is merged with the low 32 bits of a free-running counter inside the block. Reads are combinational. A write takes effect at the clock edge during which `wrEn` is high. Both fault flags are combinational and are valid in the same cycle as the access.

Index map: general scratch registers sit at 0x00 up to NUM_SCRATCH-1. The fixed registers are: 0x40 PAL base, 0x41 miscellaneous control, 0x42 exception address, 0x43/0x44 trap request/enable, 0x45 priority level, 0x46/0x47 instruction/data mode, 0x48 software interrupt request, 0x49 control/status, 0x4A/0x4B instruction/data page-table base, 0x4C cache test control, 0x4D cache mode, 0x4E miss-address mode, 0x4F instruction ASN, 0x50 data ASN, 0x51 exception summary, 0x52 exception mask, 0x53 interrupt ID, 0x54 memory-management status, 0x55 PTE temp, 0x56 cycle counter, 0x58 flush-all command, 0x59 flush-process command.

Top module: `ctl_reg_file`

## Requirements
- R1: After reset every register reads zero, except PAL base, which reads parameter PAL_RESET, and miscellaneous control, which reads 0x6.
- R2: Scratch registers, PAL base and miscellaneous control store all 64 written bits.
- R3: Trap request and trap enable keep only data & 0xF. Priority level keeps only data & 0x1F. Both mode registers keep only data & 0x18.
- R4: The exception address register stores the written data with bit 1 forced to zero.
- R5: The remaining write masks are: software interrupt 0x7FFF0, control/status 0xFF_FFFF_0300, both page-table bases 0xFFFF_FFFF_C000_0000, cache test 0x1FFB, cache mode and miss-address mode 0x3F, instruction ASN 0x7F0, data ASN 0xFE00_0000_0000_0000.
- R6: Any write to exception summary or exception mask leaves that register zero, whatever the data, with no fault.
- R7: A write to interrupt ID, memory-management status or PTE temp raises `wrFault` and leaves the register unchanged. Reads of these registers do not fault.
- R8: A write to 0x58 pulses `flushAllStb`, and a write to 0x59 pulses `flushProcStb`, in the cycle of the write, with no fault. A read of either index raises `rdFault`.
- R9: Any index not in the map raises `wrFault` on write and `rdFault` on read. A faulting read returns zero.
- R10: A read of the cycle register returns the stored bits 63:32 above bits 31:0 of a counter that advances by one every clock after reset.
- R11: `wrFault` is low whenever `wrEn` is low, and `rdFault` is low whenever `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request |
| wrIdx | input | 8 | Write index |
| wrData | input | 64 | Write data |
| wrFault | output | 1 | Write is illegal |
| rdEn | input | 1 | Read request |
| rdIdx | input | 8 | Read index |
| rdData | output | 64 | Read data, zero on fault |
| rdFault | output | 1 | Read is illegal |
| flushAllStb | output | 1 | Flush-all command strobe |
| flushProcStb | output | 1 | Flush-process command strobe |

## Verification
The assertions assume that the write and read indices are stable while their enables are high, and that reset is held for at least one clock edge. The bench meets both assumptions by changing every input only at the falling edge. It releases reset at a falling edge after several cycles. The counter-step property assumes that nothing stalls the clock. The bench runs the clock freely, so the counter difference between two reads equals the number of edges between them.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int IDX_W = 8;
  localparam int DATA_W = 64;
  localparam int NUM_FIXED = 23;

  typedef enum logic [2:0] {
    CLS_BAD, CLS_RW, CLS_RO, CLS_CMD_ALL, CLS_CMD_PROC, CLS_CYC
  } accCls_t;

  typedef struct packed {
    accCls_t cls;
    logic [IDX_W-1:0] fixedOfs;
    logic [DATA_W-1:0] mask;
  } regDesc_t;

  // offsets inside the fixed group; a register's storage slot is NUM_SCRATCH + offset
  localparam int F_PAL = 0;
  localparam int F_MISC = 1;
  localparam int F_EXCADDR = 2;
  localparam int F_PRIO = 5;
  localparam int F_EXCSUM = 17;
  localparam int F_EXCMASK = 18;
  localparam int F_CYC = 22;

  typedef struct packed {
    logic wrStb;
    logic [IDX_W-1:0] wrSlot;
    logic [DATA_W-1:0] wrMask;
    logic rdOk;
    logic rdCyc;
    logic [IDX_W-1:0] rdSlot;
  } dpStrobe_t;

  localparam logic [DATA_W-1:0] ALL1 = '1;

  function automatic regDesc_t fixedDesc(input logic [IDX_W-1:0] idx);
    regDesc_t d;
    d = '{cls: CLS_BAD, fixedOfs: '0, mask: '0};
    case (idx)
      8'h40: d = '{CLS_RW, 8'd0, ALL1};
      8'h41: d = '{CLS_RW, 8'd1, ALL1};
      8'h42: d = '{CLS_RW, 8'd2, ~64'h2};
      8'h43: d = '{CLS_RW, 8'd3, 64'hF};
      8'h44: d = '{CLS_RW, 8'd4, 64'hF};
      8'h45: d = '{CLS_RW, 8'd5, 64'h1F};
      8'h46: d = '{CLS_RW, 8'd6, 64'h18};
      8'h47: d = '{CLS_RW, 8'd7, 64'h18};
      8'h48: d = '{CLS_RW, 8'd8, 64'h7FFF0};
      8'h49: d = '{CLS_RW, 8'd9, 64'h0000_00FF_FFFF_0300};
      8'h4A: d = '{CLS_RW, 8'd10, 64'hFFFF_FFFF_C000_0000};
      8'h4B: d = '{CLS_RW, 8'd11, 64'hFFFF_FFFF_C000_0000};
      8'h4C: d = '{CLS_RW, 8'd12, 64'h1FFB};
      8'h4D: d = '{CLS_RW, 8'd13, 64'h3F};
      8'h4E: d = '{CLS_RW, 8'd14, 64'h3F};
      8'h4F: d = '{CLS_RW, 8'd15, 64'h7F0};
      8'h50: d = '{CLS_RW, 8'd16, 64'hFE00_0000_0000_0000};
      8'h51: d = '{CLS_RW, 8'd17, 64'h0};
      8'h52: d = '{CLS_RW, 8'd18, 64'h0};
      8'h53: d = '{CLS_RO, 8'd19, 64'h0};
      8'h54: d = '{CLS_RO, 8'd20, 64'h0};
      8'h55: d = '{CLS_RO, 8'd21, 64'h0};
      8'h56: d = '{CLS_CYC, 8'd22, ALL1};
      8'h58: d = '{CLS_CMD_ALL, 8'd0, 64'h0};
      8'h59: d = '{CLS_CMD_PROC, 8'd0, 64'h0};
      default: d = '{CLS_BAD, 8'd0, 64'h0};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ctl_reg_ctrl.sv
module ctl_reg_ctrl
  import ctl_reg_pkg::*;
#(
  parameter int NUM_SCRATCH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic rdEn,
  input  logic [IDX_W-1:0] rdIdx,
  output dpStrobe_t stb,
  output logic wrFault,
  output logic rdFault,
  output logic flushAllStb,
  output logic flushProcStb
);
  regDesc_t wrDesc, rdDesc;
  logic [IDX_W-1:0] wrSlot, rdSlot;

  function automatic regDesc_t lookup(input logic [IDX_W-1:0] idx,
                                      output logic [IDX_W-1:0] slot);
    regDesc_t d;
    if (int'(idx) < NUM_SCRATCH) begin
      d = '{CLS_RW, 8'd0, ALL1};
      slot = idx;
    end else begin
      d = fixedDesc(idx);
      slot = IDX_W'(NUM_SCRATCH) + d.fixedOfs;
    end
    return d;
  endfunction

  always_comb begin
    wrDesc = lookup(wrIdx, wrSlot);
    rdDesc = lookup(rdIdx, rdSlot);
  end

  always_comb begin
    wrFault      = wrEn && (wrDesc.cls == CLS_BAD || wrDesc.cls == CLS_RO);
    flushAllStb  = wrEn && wrDesc.cls == CLS_CMD_ALL;
    flushProcStb = wrEn && wrDesc.cls == CLS_CMD_PROC;
    rdFault      = rdEn && (rdDesc.cls == CLS_BAD || rdDesc.cls == CLS_CMD_ALL ||
                            rdDesc.cls == CLS_CMD_PROC);
    stb.wrStb  = wrEn && (wrDesc.cls == CLS_RW || wrDesc.cls == CLS_CYC);
    stb.wrSlot = wrSlot;
    stb.wrMask = wrDesc.mask;
    stb.rdOk   = rdEn && (rdDesc.cls == CLS_RW || rdDesc.cls == CLS_RO ||
                          rdDesc.cls == CLS_CYC);
    stb.rdCyc  = rdDesc.cls == CLS_CYC;
    stb.rdSlot = rdSlot;
  end

  AST_WRFAULT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !wrFault); // R11
  AST_RDFAULT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> !rdFault); // R11
  AST_CMD_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (flushAllStb || flushProcStb) |-> (!wrFault && !stb.wrStb)); // R8
  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({flushAllStb, flushProcStb}) <= 1); // R8
  AST_FAULT_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    wrFault |-> !stb.wrStb); // R7
endmodule

// File: rtl/ctl_reg_dp.sv
module ctl_reg_dp
  import ctl_reg_pkg::*;
#(
  parameter int NUM_SCRATCH = 4,
  parameter logic [DATA_W-1:0] PAL_RESET = 64'h0000_0000_0000_4000,
  parameter int CNT_W = 32
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobe_t stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int NSLOT = NUM_SCRATCH + NUM_FIXED;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] regs [NSLOT];
  logic [CNT_W-1:0] cycCnt;
  logic pastValid;

  function automatic logic [DATA_W-1:0] resetVal(input int s);
    if (s == NUM_SCRATCH + F_PAL) return PAL_RESET;
    if (s == NUM_SCRATCH + F_MISC) return 64'h6;
    return '0;
  endfunction

  for (genvar s = 0; s < NSLOT; s++) begin : gSlot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= resetVal(s);
      else if (stb.wrStb && int'(stb.wrSlot) == s) q <= wrData & stb.wrMask;
    end
    assign regs[s] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
      pastValid <= 1'b0;
    end else begin
      cycCnt <= cycCnt + 1'b1;
      pastValid <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdOk && int'(stb.rdSlot) < NSLOT) begin
      if (stb.rdCyc)
        rdData = {regs[stb.rdSlot][DATA_W-1:HALF], HALF'(cycCnt)};
      else
        rdData = regs[stb.rdSlot];
    end
  end

  AST_PRIO_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    regs[NUM_SCRATCH+F_PRIO][DATA_W-1:5] == '0); // R3
  AST_EXCADDR_BIT1: assert property (@(posedge clk) disable iff (!rstN)
    regs[NUM_SCRATCH+F_EXCADDR][1] == 1'b0); // R4
  AST_EXC_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (regs[NUM_SCRATCH+F_EXCSUM] | regs[NUM_SCRATCH+F_EXCMASK]) == '0); // R6
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> cycCnt == $past(cycCnt) + 1'b1); // R10
endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import ctl_reg_pkg::*;
#(
  parameter int NUM_SCRATCH = 4,
  parameter logic [63:0] PAL_RESET = 64'h0000_0000_0000_4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [7:0] wrIdx,
  input  logic [63:0] wrData,
  output logic wrFault,
  input  logic rdEn,
  input  logic [7:0] rdIdx,
  output logic [63:0] rdData,
  output logic rdFault,
  output logic flushAllStb,
  output logic flushProcStb
);
  dpStrobe_t stb;

  ctl_reg_ctrl #(.NUM_SCRATCH(NUM_SCRATCH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .rdEn(rdEn), .rdIdx(rdIdx),
    .stb(stb), .wrFault(wrFault), .rdFault(rdFault),
    .flushAllStb(flushAllStb), .flushProcStb(flushProcStb)
  );

  ctl_reg_dp #(.NUM_SCRATCH(NUM_SCRATCH), .PAL_RESET(PAL_RESET)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdData(rdData)
  );

  AST_RDFAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdFault |-> rdData == '0); // R9
endmodule

// File: tb/ctl_reg_file_test.sv
module ctl_reg_file_test;
  localparam logic [63:0] PAL_RST = 64'h0000_0000_0000_4000;
  localparam logic [63:0] ONES = '1;

  typedef struct packed {
    logic [7:0] idx;
    logic [63:0] wdata;
    logic [63:0] expRd;
    logic expWf;
    logic [7:0] req;
  } vec_t;

  // write wdata, expect wrFault = expWf, then read back expRd (no read fault)
  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0, 8'd2}, // R2
    '{8'h03, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, 1'b0, 8'd2}, // R2
    '{8'h40, 64'h1122_3344_5566_7788, 64'h1122_3344_5566_7788, 1'b0, 8'd2}, // R2
    '{8'h41, ONES, ONES, 1'b0, 8'd2},                                       // R2
    '{8'h42, ONES, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 8'd4},                    // R4
    '{8'h43, ONES, 64'hF, 1'b0, 8'd3},                                      // R3
    '{8'h44, ONES, 64'hF, 1'b0, 8'd3},
    '{8'h45, ONES, 64'h1F, 1'b0, 8'd3},
    '{8'h46, ONES, 64'h18, 1'b0, 8'd3},
    '{8'h47, ONES, 64'h18, 1'b0, 8'd3},
    '{8'h48, ONES, 64'h7FFF0, 1'b0, 8'd5},                                  // R5
    '{8'h49, ONES, 64'h0000_00FF_FFFF_0300, 1'b0, 8'd5},
    '{8'h4A, ONES, 64'hFFFF_FFFF_C000_0000, 1'b0, 8'd5},
    '{8'h4B, ONES, 64'hFFFF_FFFF_C000_0000, 1'b0, 8'd5},
    '{8'h4C, ONES, 64'h1FFB, 1'b0, 8'd5},
    '{8'h4D, ONES, 64'h3F, 1'b0, 8'd5},
    '{8'h4E, ONES, 64'h3F, 1'b0, 8'd5},
    '{8'h4F, ONES, 64'h7F0, 1'b0, 8'd5},
    '{8'h50, ONES, 64'hFE00_0000_0000_0000, 1'b0, 8'd5},
    '{8'h51, ONES, 64'h0, 1'b0, 8'd6},                                      // R6
    '{8'h52, ONES, 64'h0, 1'b0, 8'd6},
    '{8'h53, ONES, 64'h0, 1'b1, 8'd7},                                      // R7
    '{8'h55, ONES, 64'h0, 1'b1, 8'd7}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrIdx = '0, rdIdx = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic wrFault, rdFault, flushAllStb, flushProcStb;
  int nChk = 0, nBad = 0;
  logic [63:0] r1, r2;
  logic f1, sa, sp;

  always #2 clk = ~clk;

  ctl_reg_file #(.NUM_SCRATCH(4), .PAL_RESET(PAL_RST)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .wrFault(wrFault), .rdEn(rdEn), .rdIdx(rdIdx), .rdData(rdData),
    .rdFault(rdFault), .flushAllStb(flushAllStb), .flushProcStb(flushProcStb)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] idx, input logic [63:0] d,
                         output logic wf, output logic fa, output logic fp);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b1; wrIdx = idx; wrData = d;
    #1; wf = wrFault; fa = flushAllStb; fp = flushProcStb;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] idx, output logic [63:0] d, output logic f);
    @(negedge clk);
    rdEn = 1'b1; rdIdx = idx;
    #1; d = rdData; f = rdFault;
  endtask

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    doRead(8'h40, r1, f1); chk("R1 pal base", r1, PAL_RST);
    doRead(8'h41, r1, f1); chk("R1 misc ctl", r1, 64'h6);
    doRead(8'h02, r1, f1); chk("R1 scratch", r1, 64'h0);
    doRead(8'h45, r1, f1); chk("R1 priority", r1, 64'h0);
    chk("R1 no read fault", {63'd0, f1}, 64'd0);
    // R11 no enables means no faults
    @(negedge clk); rdEn = 1'b0; wrEn = 1'b0; wrIdx = 8'h30; rdIdx = 8'h30; #1;
    chk("R11 wrFault idle", {63'd0, wrFault}, 64'd0);
    chk("R11 rdFault idle", {63'd0, rdFault}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      doWrite(VECS[i].idx, VECS[i].wdata, f1, sa, sp);
      chk($sformatf("R%0d wrFault idx %h", VECS[i].req, VECS[i].idx), {63'd0, f1}, {63'd0, VECS[i].expWf});
      doRead(VECS[i].idx, r1, f1);
      chk($sformatf("R%0d read idx %h", VECS[i].req, VECS[i].idx), r1, VECS[i].expRd);
      chk($sformatf("R%0d rdFault idx %h", VECS[i].req, VECS[i].idx), {63'd0, f1}, 64'd0);
    end

    // R6 clear after a second write with other data
    doWrite(8'h51, 64'h5A5A, f1, sa, sp); doRead(8'h51, r1, f1);
    chk("R6 summary stays zero", r1, 64'h0);
    // R7 memory-management status: fault and unchanged
    doWrite(8'h54, 64'h1234, f1, sa, sp); chk("R7 mm status wrFault", {63'd0, f1}, 64'd1);
    doRead(8'h54, r1, f1); chk("R7 mm status unchanged", r1, 64'h0);
    // R3 masked write of a pattern
    doWrite(8'h45, 64'hFFFF_0000_0000_00E3, f1, sa, sp); doRead(8'h45, r1, f1);
    chk("R3 priority pattern", r1, 64'h3);

    // R8 command strobes
    doWrite(8'h58, 64'h1, f1, sa, sp);
    chk("R8 flush-all strobe", {62'd0, sa, sp}, 64'b10);
    chk("R8 flush-all no fault", {63'd0, f1}, 64'd0);
    doWrite(8'h59, 64'h1, f1, sa, sp);
    chk("R8 flush-proc strobe", {62'd0, sa, sp}, 64'b01);
    @(negedge clk); #1;
    chk("R8 strobes idle", {62'd0, flushAllStb, flushProcStb}, 64'd0);
    doRead(8'h58, r1, f1); chk("R8 read fault", {63'd0, f1}, 64'd1);
    chk("R8 read data zero", r1, 64'h0);

    // R9 unmapped indices
    doWrite(8'h30, ONES, f1, sa, sp); chk("R9 write fault 0x30", {63'd0, f1}, 64'd1);
    doWrite(8'hFF, ONES, f1, sa, sp); chk("R9 write fault 0xFF", {63'd0, f1}, 64'd1);
    doRead(8'h57, r1, f1); chk("R9 read fault 0x57", {63'd0, f1}, 64'd1);
    chk("R9 read data zero", r1, 64'h0);
    doRead(8'h03, r1, f1); chk("R9 scratch untouched", r1, 64'hFEDC_BA98_7654_3210);

    // R10 cycle register
    doWrite(8'h56, 64'hAAAA_BBBB_CCCC_DDDD, f1, sa, sp);
    doRead(8'h56, r1, f1);
    repeat (9) @(negedge clk);
    doRead(8'h56, r2, f1);
    chk("R10 upper half first", {32'd0, r1[63:32]}, 64'hAAAA_BBBB);
    chk("R10 upper half second", {32'd0, r2[63:32]}, 64'hAAAA_BBBB);
    chk("R10 lower advance", {32'd0, r2[31:0] - r1[31:0]}, 64'd10);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule